// File: doc/BRIEF.md
# Modem Line Edge-Detect Interrupt Unit

This block sits beside a UART's data paths and owns its modem handshake lines. Four asynchronous inputs enter through a synchronizer: clear-to-send, carrier detect, ring indicator and data-set-ready. Their settled levels can be read from a status register. A change on clear-to-send or on carrier detect sets a sticky per-line status bit. Reading the status register clears these bits.

Each of the two watched lines has its own enable bit. Any enabled pending line drives one combined source. That source passes through a further enable to become the external-input interrupt. A control register drives the data-terminal-ready and request-to-send pins with inverted polarity. The same register holds a loopback switch that sends the transmit bit straight back to the receive side.

Software uses a three-register read/write port. Reads return data one cycle after the request.

Top module: `mdm_line_irq`

## Requirements
- R1: The modem register (address 1) reports the synchronized levels in bits [3:0]: bit 0 clear-to-send, bit 1 carrier detect, bit 2 ring indicator, bit 3 data-set-ready. Reads return data in the cycle after the request.
- R2: When a line's any-edge bit is 0, only a rising edge of its synchronized level sets its status bit. The any-edge bits are modem register bit 6 for clear-to-send and bit 7 for carrier detect. The status bits are bit 8 for clear-to-send and bit 9 for carrier detect.
- R3: When a line's any-edge bit is 1, both rising and falling edges set its status bit.
- R4: A read of the modem register clears both status bits. Reads of other registers, and register writes, leave the status bits unchanged.
- R5: An edge detected in the same cycle as the clearing read remains pending afterwards.
- R6: ext_irq is 1 exactly when the external enable (address 2, bit 0) is 1 and a pending line has its line enable set (modem register bit 4 for clear-to-send, bit 5 for carrier detect). Address 2, bit 1 reads the combined source before the external enable. Status bits are set regardless of any enable.
- R7: The dtr_out pin is the complement of control register (address 0) bit 0. The rts_out pin is the complement of bit 1. Writing 1 drives the pin low.
- R8: With control bit 2 set, rx_bit follows tx_bit and tx_pin is held at 1. With the bit clear, rx_bit follows rx_pin and tx_pin follows tx_bit.
- R9: After reset, all registers read 0, dtr_out and rts_out are 1, and ext_irq is 0.
- R10: Edges on the ring indicator and data-set-ready lines never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select (0 control, 1 modem, 2 interrupt) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| dcd_in | input | 1 | Carrier-detect input, asynchronous |
| ri_in | input | 1 | Ring-indicator input, asynchronous |
| dsr_in | input | 1 | Data-set-ready input, asynchronous |
| dtr_out | output | 1 | Data-terminal-ready pin, inverted from register |
| rts_out | output | 1 | Request-to-send pin, inverted from register |
| tx_bit | input | 1 | Serial bit from the transmitter |
| tx_pin | output | 1 | Serial line output |
| rx_pin | input | 1 | Serial line input |
| rx_bit | output | 1 | Serial bit to the receiver |
| ext_irq | output | 1 | External-input interrupt source |

## Verification
The assertions check several rules on every cycle. Pin polarity must follow each control write, and loopback routing must take effect after the write. A detected edge must always become pending. A clearing read must drop everything except same-cycle edges, and without a read or an edge the pending state must hold. ext_irq may never rise with nothing pending. Other behaviours can only be shown by the bench's scenarios: the difference between rising-only and any-edge detection, the full sweep of reported levels, the silence of the ring and data-set-ready lines, and the exact cycle alignment of an edge against a clearing read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 2;
    localparam int LINES      = 4;
    localparam int EDGE_LINES = 2;

    localparam int LVL_LSB    = 0;
    localparam int EN_LSB     = LVL_LSB + LINES;
    localparam int ANY_LSB    = EN_LSB + EDGE_LINES;
    localparam int STAT_LSB   = ANY_LSB + EDGE_LINES;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LINE  = 2'd0,
        SEL_MODEM = 2'd1,
        SEL_IRQ   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic loopback;
        logic rts_set;
        logic dtr_set;
    } line_ctl_t;

    typedef struct packed {
        logic [EDGE_LINES-1:0] any_edge;
        logic [EDGE_LINES-1:0] line_en;
    } edge_cfg_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic any);
        return any ? (cur ^ prev) : (cur & ~prev);
    endfunction

    function automatic logic [DATA_W-1:0] pack_modem(
        input logic [LINES-1:0]      lvl,
        input edge_cfg_t             cfg,
        input logic [EDGE_LINES-1:0] pend
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[LVL_LSB  +: LINES]      = lvl;
        w[EN_LSB   +: EDGE_LINES] = cfg.line_en;
        w[ANY_LSB  +: EDGE_LINES] = cfg.any_edge;
        w[STAT_LSB +: EDGE_LINES] = pend;
        return w;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic any_edge,
    input  logic clear,
    output logic hit,
    output logic pending
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign hit = edge_hit(level, prev_q, any_edge);

    // a same-cycle edge wins over the clearing read
    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= (pending & ~clear) | hit;
    end
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [LINES-1:0]      levels,
    input  logic [EDGE_LINES-1:0] pending,
    input  logic                  src_active,
    output line_ctl_t             ctl,
    output edge_cfg_t             cfg,
    output logic                  ext_en,
    output logic                  clear_pend,
    output logic [DATA_W-1:0]     rdata
);
    localparam int CTL_W = $bits(line_ctl_t);

    reg_sel_e sel;
    assign sel        = reg_sel_e'(addr);
    assign clear_pend = rd && (sel == SEL_MODEM);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            cfg    <= '0;
            ext_en <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_LINE:  ctl <= line_ctl_t'(wdata[CTL_W-1:0]);
                SEL_MODEM: begin
                    cfg.line_en  <= wdata[EN_LSB  +: EDGE_LINES];
                    cfg.any_edge <= wdata[ANY_LSB +: EDGE_LINES];
                end
                SEL_IRQ:   ext_en <= wdata[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                SEL_LINE:  rdata <= {{(DATA_W-CTL_W){1'b0}}, ctl};
                SEL_MODEM: rdata <= pack_modem(levels, cfg, pending);
                SEL_IRQ:   rdata <= {{(DATA_W-2){1'b0}}, src_active, ext_en};
                default:   rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mdm_line_irq.sv
module mdm_line_irq
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cts_in,
    input  logic              dcd_in,
    input  logic              ri_in,
    input  logic              dsr_in,
    output logic              dtr_out,
    output logic              rts_out,
    input  logic              tx_bit,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rx_bit,
    output logic              ext_irq
);
    logic [LINES-1:0]      levels;
    logic [EDGE_LINES-1:0] edge_pend;
    logic [EDGE_LINES-1:0] edge_hit_w;
    logic                  clear_pend;
    logic                  src_active;
    logic                  ext_en;
    line_ctl_t             ctl;
    edge_cfg_t             cfg;

    mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({dsr_in, ri_in, dcd_in, cts_in}),
        .sync_out (levels)
    );

    for (genvar g = 0; g < EDGE_LINES; g++) begin : g_edge
        mdm_edge u_edge (
            .clk      (clk),
            .rst      (rst),
            .level    (levels[g]),
            .any_edge (cfg.any_edge[g]),
            .clear    (clear_pend),
            .hit      (edge_hit_w[g]),
            .pending  (edge_pend[g])
        );
    end

    assign src_active = |(edge_pend & cfg.line_en);
    assign ext_irq    = ext_en & src_active;

    mdm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .levels     (levels),
        .pending    (edge_pend),
        .src_active (src_active),
        .ctl        (ctl),
        .cfg        (cfg),
        .ext_en     (ext_en),
        .clear_pend (clear_pend),
        .rdata      (reg_rdata)
    );

    assign dtr_out = ~ctl.dtr_set;
    assign rts_out = ~ctl.rts_set;
    assign tx_pin  = ctl.loopback ? 1'b1   : tx_bit;
    assign rx_bit  = ctl.loopback ? tx_bit : rx_pin;
endmodule

// File: rtl/mdm_line_irq_chk.sv
module mdm_line_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        dtr_out,
    input logic        rts_out,
    input logic        tx_bit,
    input logic        tx_pin,
    input logic        rx_bit,
    input logic        ext_irq,
    input logic [1:0]  pending,
    input logic [1:0]  hit
);
    // R7
    pin_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=>
            (dtr_out == !$past(reg_wdata[0]) && rts_out == !$past(reg_wdata[1])));

    // R8
    loop_route_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[2]) |=> (rx_bit == tx_bit && tx_pin));

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd1) |=> ((pending & ~$past(hit)) == 2'b00));

    // R5
    edge_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != 2'b00) |=> ((pending & $past(hit)) == $past(hit)));

    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(reg_rd && reg_addr == 2'd1) && hit == 2'b00) |=> (pending == $past(pending)));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        ext_irq |-> (pending != 2'b00));
endmodule

bind mdm_line_irq mdm_line_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dtr_out   (dtr_out),
    .rts_out   (rts_out),
    .tx_bit    (tx_bit),
    .tx_pin    (tx_pin),
    .rx_bit    (rx_bit),
    .ext_irq   (ext_irq),
    .pending   (edge_pend),
    .hit       (edge_hit_w)
);

// File: tb/tb_mdm_line_irq.sv
module tb_mdm_line_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [3:0]  pins = 4'h0;
    logic        dtr_out, rts_out, tx_pin, rx_bit, ext_irq;
    logic        tx_bit = 1'b0;
    logic        rx_pin = 1'b1;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    mdm_line_irq dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cts_in(pins[0]), .dcd_in(pins[1]), .ri_in(pins[2]), .dsr_in(pins[3]),
        .dtr_out(dtr_out), .rts_out(rts_out), .tx_bit(tx_bit), .tx_pin(tx_pin),
        .rx_pin(rx_pin), .rx_bit(rx_bit), .ext_irq(ext_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check("R9 dtr", {15'h0, dtr_out}, 16'h1);
        check("R9 rts", {15'h0, rts_out}, 16'h1);
        check("R9 irq", {15'h0, ext_irq}, 16'h0);
        check("R9 rdata", reg_rdata, 16'h0);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), rv);
            check("R9 reg", rv, 16'h0);
        end

        // R1 level sweep
        for (int p = 0; p < 16; p++) begin
            pins = 4'(p);
            settle();
            rd(2'd1, rv);
            check("R1 levels", {12'h0, rv[3:0]}, 16'(p));
        end
        pins = 4'h0;
        settle();

        // R2 / R3 edge sweep
        for (int l = 0; l < 2; l++) begin
            for (int ns = 0; ns < 2; ns++) begin
                wr(2'd1, 16'(ns << (6 + l)));
                rd(2'd1, rv);
                rd(2'd1, rv);
                check("R4 cleared", {14'h0, rv[9:8]}, 16'h0);
                pins[l] = 1'b1;
                settle();
                rd(2'd1, rv);
                check(ns ? "R3 rise" : "R2 rise", {14'h0, rv[9:8]}, 16'(1 << l));
                rd(2'd1, rv);
                check("R4 read clear", {14'h0, rv[9:8]}, 16'h0);
                pins[l] = 1'b0;
                settle();
                rd(2'd1, rv);
                check(ns ? "R3 fall" : "R2 fall", {14'h0, rv[9:8]}, 16'(ns << l));
            end
        end

        // R10 ring and data-set-ready never flag
        wr(2'd1, 16'h00C0);
        rd(2'd1, rv);
        pins = 4'b1100;
        settle();
        pins = 4'b0000;
        settle();
        rd(2'd1, rv);
        check("R10 no status", {14'h0, rv[9:8]}, 16'h0);

        // R5 edge coinciding with the clearing read
        wr(2'd1, 16'h0000);
        rd(2'd1, rv);
        pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd1, rv);
        check("R5 before", {14'h0, rv[9:8]}, 16'h0);
        rd(2'd1, rv);
        check("R5 kept", {14'h0, rv[9:8]}, 16'h1);
        pins[0] = 1'b0;
        settle();
        rd(2'd1, rv);

        // R6 interrupt combining
        wr(2'd1, 16'h0010);
        wr(2'd2, 16'h0001);
        rd(2'd1, rv);
        check("R6 idle", {15'h0, ext_irq}, 16'h0);
        pins[0] = 1'b1;
        settle();
        check("R6 raised", {15'h0, ext_irq}, 16'h1);
        wr(2'd2, 16'h0000);
        check("R6 ext mask", {15'h0, ext_irq}, 16'h0);
        rd(2'd2, rv);
        check("R6 source bit", rv, 16'h0002);
        rd(2'd1, rv);
        check("R4 irq read keeps", {14'h0, rv[9:8]}, 16'h1);
        wr(2'd2, 16'h0001);
        pins[1] = 1'b1;
        settle();
        check("R6 line mask", {15'h0, ext_irq}, 16'h0);
        rd(2'd1, rv);
        check("R6 status unmasked", {14'h0, rv[9:8]}, 16'h2);
        pins = 4'h0;
        settle();
        rd(2'd1, rv);

        // R7 pin polarity
        for (int v = 0; v < 4; v++) begin
            wr(2'd0, 16'(v));
            check("R7 dtr", {15'h0, dtr_out}, 16'(~v & 1));
            check("R7 rts", {15'h0, rts_out}, 16'((~v >> 1) & 1));
            rd(2'd0, rv);
            check("R7 readback", rv, 16'(v));
        end

        // R8 loopback routing
        for (int lp = 0; lp < 2; lp++) begin
            wr(2'd0, 16'(lp << 2));
            for (int t = 0; t < 2; t++) begin
                tx_bit = t[0];
                rx_pin = ~t[0];
                #1;
                check("R8 rx", {15'h0, rx_bit}, 16'(lp ? t : 1 - t));
                check("R8 tx", {15'h0, tx_pin}, 16'(lp ? 1 : t));
            end
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule